// File: doc/BRIEF.md
# Multi-source reset controller

This block turns several independent reset requests into one registered chip reset that is stretched for a fixed number of clock cycles. The requests are a power-on pulse, a shared pin that can act as an active-low reset input, a watchdog expiry, a software-written reset bit and a power-monitor trip. The power-on and supply detectors are analog and sit outside the block. Here they appear as digital request inputs. The power-on input also acts as the block's own asynchronous reset.

A configuration input decides what the shared pin does. In general-purpose mode (the default) the pin's level is synchronised and passed to a port read path, and it never resets the chip. In reset mode a low level on the pin holds the chip in reset. A watchdog expiry only counts when its enable input is set. A cause register records which sources started or joined the most recent reset, so that boot code can read why the chip restarted. All pins are plain level signals. No data stream crosses the block, so it has no valid/ready handshake.

Top module: `chip_rst_ctrl`

## Requirements
- R1: While `por_req` is high, `chip_rst` is 1, `cause` is 5'b00001, `sw_rst_bit` is 0 and `pin_data` is 1. After `por_req` falls, `chip_rst` stays high until the (HOLD+1)-th rising edge and is low after that edge.
- R2: With `cfg_pin_gpio`=1 the pin never asserts `chip_rst`. `pin_data` equals the pin level sampled two rising edges earlier (the synchroniser depth).
- R3: With `cfg_pin_gpio`=0, a low pin level asserts `chip_rst` three rising edges after it is applied (two synchroniser flops and the output register), and reset stays high while the pin stays low. In this mode `pin_data` reads 1.
- R4: `wdt_expire` requests reset only while `cfg_wdt_en`=1. With the enable at 0, an expiry leaves both `chip_rst` and `cause` unchanged.
- R5: A `sw_rst_set` pulse sets `sw_rst_bit` at the next edge. `chip_rst` rises one edge later, and `sw_rst_bit` clears on that same edge. A `sw_rst_set` pulse while `chip_rst` is high is ignored.
- R6: `pmon_trip` is a reset request, combined by OR with the other sources.
- R7: A request present at N consecutive sampling edges makes `chip_rst` high for exactly N+HOLD clock cycles, starting at the first of those edges.
- R8: A request that arrives while the reset is being stretched reloads the hold count, so the stretch is measured from the last request.
- R9: The cause bits are: [0] power-on, [1] pin, [2] watchdog, [3] software, [4] power monitor. A request that starts a new reset replaces `cause` with the set of active sources. A request that arrives while `chip_rst` is high is added by OR. Power-on alone sets bit 0.
- R10: Requests that arrive at the same edge start a single reset, and each of their cause bits is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on request, active high, asynchronous; also resets the block |
| cfg_pin_gpio | input | 1 | 1: shared pin is a data input; 0: shared pin is an active-low reset |
| cfg_wdt_en | input | 1 | Allows watchdog expiry to reset the chip |
| pin_shared | input | 1 | Shared pin level, asynchronous |
| wdt_expire | input | 1 | Watchdog timeout request |
| sw_rst_set | input | 1 | Software write that sets the reset bit |
| pmon_trip | input | 1 | Power-monitor trip request |
| chip_rst | output | 1 | Registered, stretched chip reset, active high |
| pin_data | output | 1 | Synchronised pin level for the port read path (1 in reset mode) |
| sw_rst_bit | output | 1 | Current state of the software reset bit |
| cause | output | 5 | Sources of the most recent reset |

## Verification
A watchdog expiry and a power-monitor trip can hit the same sampling edge. The bench provokes this both directly and through random subsets of those two sources with random hold lengths. The result is judged by requiring one reset whose length is N+HOLD and whose cause holds both bits. A second overlap is a request that lands inside an active stretch. This is provoked with a watchdog pulse followed a few cycles later by a power-monitor pulse, and the bench expects a lengthened reset with both cause bits ORed in rather than replaced.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NCAUSE   = 5;
  localparam int C_POR    = 0;
  localparam int C_PIN    = 1;
  localparam int C_WDT    = 2;
  localparam int C_SW     = 3;
  localparam int C_PMON   = 4;
  typedef logic [NCAUSE-1:0] cause_t;
  localparam cause_t CAUSE_POR_ONLY = cause_t'(1) << C_POR;
endpackage

// File: rtl/rstc_pin_sync.sv
module rstc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic pin_i,
  input  logic gpio_mode,
  output logic data_o,
  output logic rst_req_o
);
  logic [STAGES-1:0] sh_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or posedge arst) begin
        if (arst) sh_q[0] <= 1'b1;
        else      sh_q[0] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or posedge arst) begin
        if (arst) sh_q[i] <= 1'b1;
        else      sh_q[i] <= sh_q[i-1];
      end
    end
  end

  // Reset mode reads back as a steady 1; data mode forwards the synced level.
  assign data_o    = gpio_mode ? sh_q[STAGES-1] : 1'b1;
  assign rst_req_o = !gpio_mode && !sh_q[STAGES-1];
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int HOLD = 64
) (
  input  logic clk,
  input  logic arst,
  input  logic req_i,
  output logic rst_o
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt_q;
  logic          rst_q;

  // Any request reloads the count; the output stays high until it drains.
  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      cnt_q <= CW'(HOLD);
      rst_q <= 1'b1;
    end else begin
      rst_q <= req_i || (cnt_q != '0);
      if (req_i)              cnt_q <= CW'(HOLD);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rst_o = rst_q;
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause
  import rstc_pkg::*;
(
  input  logic   clk,
  input  logic   arst,
  input  logic   active_i,
  input  cause_t req_i,
  output cause_t cause_o
);
  cause_t cause_q;

  // A fresh reset replaces the record; requests during reset accumulate.
  always_ff @(posedge clk or posedge arst) begin
    if (arst)            cause_q <= CAUSE_POR_ONLY;
    else if (|req_i)     cause_q <= active_i ? (cause_q | req_i) : req_i;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/chip_rst_ctrl.sv
module chip_rst_ctrl
  import rstc_pkg::*;
#(
  parameter int HOLD        = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_req,
  input  logic               cfg_pin_gpio,
  input  logic               cfg_wdt_en,
  input  logic               pin_shared,
  input  logic               wdt_expire,
  input  logic               sw_rst_set,
  input  logic               pmon_trip,
  output logic               chip_rst,
  output logic               pin_data,
  output logic               sw_rst_bit,
  output logic [NCAUSE-1:0]  cause
);
  logic   pin_req;
  logic   sw_q;
  logic   rst_int;
  logic   req_any;
  cause_t req_vec;
  cause_t cause_int;

  rstc_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk       (clk),
    .arst      (por_req),
    .pin_i     (pin_shared),
    .gpio_mode (cfg_pin_gpio),
    .data_o    (pin_data),
    .rst_req_o (pin_req)
  );

  // Software bit: set by a write when not in reset, cleared as reset begins.
  always_ff @(posedge clk or posedge por_req) begin
    if (por_req)      sw_q <= 1'b0;
    else if (sw_q)    sw_q <= 1'b0;
    else if (sw_rst_set && !rst_int) sw_q <= 1'b1;
  end

  always_comb begin
    req_vec         = '0;
    req_vec[C_PIN]  = pin_req;
    req_vec[C_WDT]  = wdt_expire && cfg_wdt_en;
    req_vec[C_SW]   = sw_q;
    req_vec[C_PMON] = pmon_trip;
  end
  assign req_any = |req_vec;

  rstc_stretch #(.HOLD(HOLD)) u_stretch (
    .clk   (clk),
    .arst  (por_req),
    .req_i (req_any),
    .rst_o (rst_int)
  );

  rstc_cause u_cause (
    .clk      (clk),
    .arst     (por_req),
    .active_i (rst_int),
    .req_i    (req_vec),
    .cause_o  (cause_int)
  );

  assign chip_rst   = rst_int;
  assign sw_rst_bit = sw_q;
  assign cause      = cause_int;
endmodule

// File: rtl/chip_rst_ctrl_chk.sv
module chip_rst_ctrl_chk (
  input logic       clk,
  input logic       por_req,
  input logic       cfg_pin_gpio,
  input logic       cfg_wdt_en,
  input logic       chip_rst,
  input logic       sw_rst_bit,
  input logic       req_any,
  input logic [4:0] cause
);
  p_req_starts_r7: assert property (@(posedge clk) disable iff (por_req)
    req_any |=> chip_rst);

  p_release_quiet_r7: assert property (@(posedge clk) disable iff (por_req)
    $fell(chip_rst) |-> $past(!req_any));

  p_sw_selfclear_r5: assert property (@(posedge clk) disable iff (por_req)
    sw_rst_bit |=> !sw_rst_bit);

  p_cause_grows_r9: assert property (@(posedge clk) disable iff (por_req)
    $past(chip_rst) |-> ((cause & $past(cause)) == $past(cause)));

  p_pin_gpio_quiet_r2: assert property (@(posedge clk) disable iff (por_req)
    $rose(cause[1]) |-> $past(!cfg_pin_gpio));

  p_wdt_gated_r4: assert property (@(posedge clk) disable iff (por_req)
    $rose(cause[2]) |-> $past(cfg_wdt_en));
endmodule

bind chip_rst_ctrl chip_rst_ctrl_chk u_chk (
  .clk          (clk),
  .por_req      (por_req),
  .cfg_pin_gpio (cfg_pin_gpio),
  .cfg_wdt_en   (cfg_wdt_en),
  .chip_rst     (chip_rst),
  .sw_rst_bit   (sw_rst_bit),
  .req_any      (req_any),
  .cause        (cause)
);

// File: tb/tb_chip_rst_ctrl.sv
module tb_chip_rst_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 8;

  logic       clk = 1'b0;
  logic       por_req, cfg_pin_gpio, cfg_wdt_en, pin_shared;
  logic       wdt_expire, sw_rst_set, pmon_trip;
  logic       chip_rst, pin_data, sw_rst_bit;
  logic [4:0] cause;

  int checks = 0;
  int failures = 0;

  chip_rst_ctrl #(.HOLD(HOLD), .SYNC_STAGES(2)) dut (
    .clk(clk), .por_req(por_req), .cfg_pin_gpio(cfg_pin_gpio),
    .cfg_wdt_en(cfg_wdt_en), .pin_shared(pin_shared), .wdt_expire(wdt_expire),
    .sw_rst_set(sw_rst_set), .pmon_trip(pmon_trip), .chip_rst(chip_rst),
    .pin_data(pin_data), .sw_rst_bit(sw_rst_bit), .cause(cause)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic int exp_len(input int n);
    return n + HOLD;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    pin_shared = 1'b1; wdt_expire = 1'b0; sw_rst_set = 1'b0; pmon_trip = 1'b0;
  endtask

  // Drives mask bits (1 pin, 2 wdt, 4 pmon) for n cycles; returns reset length.
  task automatic drive_measure(input logic [4:0] mask, input int n, output int len);
    bit seen = 0;
    len = 0;
    @(negedge clk);
    pin_shared = !mask[1]; wdt_expire = mask[2]; pmon_trip = mask[4];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (chip_rst) begin len++; seen = 1; end
    end
    idle_inputs();
    for (int g = 0; g < 1000; g++) begin
      @(negedge clk);
      if (chip_rst) begin len++; seen = 1; end
      else if (seen) break;
    end
  endtask

  int len;
  int d1, d2;

  initial begin
    void'($urandom(32'd1234));
    idle_inputs();
    por_req = 1'b1; cfg_pin_gpio = 1'b1; cfg_wdt_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 rst during por", chip_rst, 1);
    chk("R1 cause during por", cause, 5'b00001);
    chk("R1 sw bit during por", sw_rst_bit, 0);
    chk("R1 pin_data during por", pin_data, 1);
    @(posedge clk); #1 por_req = 1'b0;
    len = 0;
    for (int g = 0; g < 1000; g++) begin
      @(negedge clk);
      if (!chip_rst) break;
      len++;
    end
    chk("R1 por stretch", len, HOLD + 1);

    // R2: data mode, random pin levels, no reset
    d1 = 1; d2 = 1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk("R2 pin_data", pin_data, d2);
      chk("R2 no reset", chip_rst, 0);
      d2 = d1;
      pin_shared = 1'($urandom_range(0, 1));
      d1 = pin_shared;
    end
    @(negedge clk); pin_shared = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 cause kept", cause, 5'b00001);

    // R3: reset mode
    cfg_pin_gpio = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 high pin no reset", chip_rst, 0);
    chk("R3 pin_data reads 1", pin_data, 1);
    @(negedge clk); pin_shared = 1'b0;
    @(negedge clk); chk("R3 latency edge1", chip_rst, 0);
    @(negedge clk); chk("R3 latency edge2", chip_rst, 0);
    @(negedge clk); chk("R3 latency edge3", chip_rst, 1);
    pin_shared = 1'b1;
    repeat (HOLD + 4) @(negedge clk);
    drive_measure(5'b00010, 12, len);
    chk("R3 pin held len", len, exp_len(12));
    chk("R9 cause pin", cause, 5'b00010);
    cfg_pin_gpio = 1'b1;

    // R4: watchdog gating
    cfg_wdt_en = 1'b0;
    @(negedge clk); wdt_expire = 1'b1;
    repeat (3) @(negedge clk);
    wdt_expire = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 disabled wdt no reset", chip_rst, 0);
    chk("R4 disabled wdt cause", cause, 5'b00010);
    cfg_wdt_en = 1'b1;
    drive_measure(5'b00100, 1, len);
    chk("R4 enabled wdt len", len, exp_len(1));
    chk("R9 cause wdt", cause, 5'b00100);

    // R5: software bit
    @(negedge clk); sw_rst_set = 1'b1;
    @(negedge clk); sw_rst_set = 1'b0;
    chk("R5 bit set", sw_rst_bit, 1);
    chk("R5 not yet reset", chip_rst, 0);
    @(negedge clk);
    chk("R5 bit self cleared", sw_rst_bit, 0);
    chk("R5 reset started", chip_rst, 1);
    len = 1;
    sw_rst_set = 1'b1;
    @(negedge clk); sw_rst_set = 1'b0;
    if (chip_rst) len++;
    chk("R5 set ignored in reset", sw_rst_bit, 0);
    for (int g = 0; g < 1000; g++) begin
      @(negedge clk);
      if (!chip_rst) break;
      len++;
    end
    chk("R5 sw reset len", len, exp_len(1));
    chk("R9 cause sw", cause, 5'b01000);

    // R6: power monitor
    drive_measure(5'b10000, 3, len);
    chk("R6 pmon len", len, exp_len(3));
    chk("R6 cause pmon", cause, 5'b10000);

    // R8: request inside stretch restarts count, R9 OR accumulation
    len = 0;
    @(negedge clk); wdt_expire = 1'b1;
    @(negedge clk); wdt_expire = 1'b0; if (chip_rst) len++;
    repeat (4) begin @(negedge clk); if (chip_rst) len++; end
    pmon_trip = 1'b1;
    @(negedge clk); pmon_trip = 1'b0; if (chip_rst) len++;
    for (int g = 0; g < 1000; g++) begin
      @(negedge clk);
      if (!chip_rst) break;
      len++;
    end
    chk("R8 restart len", len, 4 + 2 + HOLD);
    chk("R9 cause accumulated", cause, 5'b10100);

    // R10: same-edge requests
    drive_measure(5'b00100, 1, len);
    chk("R9 cause overwritten", cause, 5'b00100);
    drive_measure(5'b10100, 2, len);
    chk("R10 same edge len", len, exp_len(2));
    chk("R10 same edge cause", cause, 5'b10100);

    // Random mix of watchdog and power-monitor requests
    for (int k = 0; k < 20; k++) begin
      logic [4:0] m;
      int n;
      case ($urandom_range(0, 2))
        0:       m = 5'b00100;
        1:       m = 5'b10000;
        default: m = 5'b10100;
      endcase
      n = $urandom_range(1, 6);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      drive_measure(m, n, len);
      chk("R7 random len", len, exp_len(n));
      chk("R10 random cause", cause, m);
    end

    // R1/R9: power-on again resets the cause record
    @(posedge clk); #1 por_req = 1'b1;
    @(negedge clk);
    chk("R9 por cause", cause, 5'b00001);
    chk("R1 por reset", chip_rst, 1);
    @(posedge clk); #1 por_req = 1'b0;
    repeat (HOLD + 3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule